// File: doc/BRIEF.md
# Register-Condition Branch Evaluator

This block resolves a branch whose outcome depends only on the contents of one 64-bit integer register, with no condition flags involved. Each issue cycle it receives the instruction word found at the current program counter and the value of the source register that the word names. It recognises the branch form, checks its reserved bits, tests the register against zero as a signed number, rebuilds the PC-relative displacement from two separated fields, and works out the branch target.

The block owns the program-counter pair of a machine with one delay slot. On every accepted issue the current next-PC becomes the PC, and the new next-PC is either the target (branch taken) or the sequential address. A branch that falls through with its annul bit set marks the following slot as killed: the word issued there is ignored and the pair simply advances. A malformed branch raises an illegal-instruction output and freezes the pair so that a trap handler outside the block can take over. The prediction hint carried in the word is handed to an outside predictor unchanged.

Top module: `rcb_branch_unit`

## Requirements
- R1: While reset is held and just after it, the PC equals RESET_PC, the next-PC equals RESET_PC + 4 and the slot-kill flag is clear.
- R2: A word is a register branch only when bits 31:30 are 00 and bits 24:22 are 011; any other word advances the pair sequentially (PC takes next-PC, next-PC adds 4) with no taken, illegal or hint output.
- R3: Condition field bits 27:25 with code 1 takes the branch when the register is zero, code 2 when it is zero or negative, code 3 when it is negative, the register read as two's-complement 64-bit.
- R4: Codes 5, 6 and 7 are the inverses of codes 1, 2 and 3: not zero, greater than zero, and zero or positive.
- R5: The target is the PC of the branch plus four times the sign-extended 16-bit displacement formed by word bits 21:20 (upper two bits) joined above word bits 13:0.
- R6: On a taken branch the PC takes the old next-PC (the delay slot) and the next-PC takes the target, one clock after the issue.
- R7: A not-taken branch with the annul bit (bit 29) set raises the slot-kill flag for the next issue; that issue produces no taken, illegal or hint output whatever its word holds, advances the pair sequentially and clears the flag.
- R8: A taken branch, or a not-taken branch with the annul bit clear, leaves the slot-kill flag clear.
- R9: A branch word with bit 28 set, or with condition code 0 or 4, raises the illegal output, is never taken, leaves the PC pair unchanged and does not set the slot-kill flag.
- R10: The hint output copies word bit 19 for an issued, unkilled branch word and is zero otherwise; it has no effect on the outcome.
- R11: In a cycle without issue the PC pair and the slot-kill flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | An instruction word is presented this cycle |
| instr_i | input | 32 | Instruction word fetched at pc_o |
| rs_value_i | input | XLEN | Contents of the source register named by src_reg_o |
| pc_o | output | AW | Address of the instruction now issuing |
| npc_o | output | AW | Address of the instruction after it |
| slot_kill_o | output | 1 | The instruction now issuing is annulled |
| is_branch_o | output | 1 | Issued, unkilled word is a register branch |
| br_taken_o | output | 1 | Branch condition met and encoding legal |
| br_target_o | output | AW | Computed branch target |
| illegal_o | output | 1 | Reserved encoding on an issued, unkilled branch |
| hint_o | output | 1 | Prediction hint for an outside predictor |
| src_reg_o | output | 5 | Source register index, word bits 18:14 |

## Verification
The annul of a delay slot and the decode of the word sitting in that slot fall into the same cycle: the kill flag from the previous branch must win over whatever the new word would do. The bench provokes this by following an annulling not-taken branch with a branch whose condition holds, and in another run with a branch carrying a reserved condition code. It judges each case by requiring no taken, illegal or hint output in the killed cycle, a plain sequential advance of the PC pair afterwards, and normal behaviour again in the issue that follows.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    localparam int INSN_W  = 32;
    localparam int DISP_W  = 16;
    localparam int DISP_LO = 14;
    localparam int REG_IDX = 5;

    localparam logic [1:0] OP_BRANCH_GRP = 2'b00;
    localparam logic [2:0] OP2_REG_BR    = 3'b011;

    typedef struct packed {
        logic                 is_reg_br;
        logic                 annul;
        logic                 rsvd_bit;
        logic [2:0]           cond;
        logic                 hint;
        logic [REG_IDX-1:0]   src_reg;
        logic [DISP_W-1:0]    disp;
    } rcb_fields_t;

endpackage

// File: rtl/rcb_field_decode.sv
module rcb_field_decode
    import rcb_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    output rcb_fields_t       fields_o
);

    logic [1:0]           disp_hi;
    logic [DISP_LO-1:0]   disp_lo;

    always_comb begin
        disp_hi = word_i[21:20];
        disp_lo = word_i[DISP_LO-1:0];

        fields_o.is_reg_br = (word_i[31:30] == OP_BRANCH_GRP) &&
                             (word_i[24:22] == OP2_REG_BR);
        fields_o.annul     = word_i[29];
        fields_o.rsvd_bit  = word_i[28];
        fields_o.cond      = word_i[27:25];
        fields_o.hint      = word_i[19];
        fields_o.src_reg   = word_i[18:14];
        fields_o.disp      = {disp_hi, disp_lo};
    end

endmodule

// File: rtl/rcb_cond_eval.sv
module rcb_cond_eval #(
    parameter int XLEN = 64
) (
    input  logic [2:0]      cond_i,
    input  logic [XLEN-1:0] value_i,
    output logic            cond_true_o,
    output logic            cond_legal_o
);

    logic is_zero;
    logic is_neg;
    logic base;

    always_comb begin
        is_zero = (value_i == '0);
        is_neg  = value_i[XLEN-1];
        unique case (cond_i[1:0])
            2'b01:   base = is_zero;
            2'b10:   base = is_zero | is_neg;
            2'b11:   base = is_neg;
            default: base = 1'b0;
        endcase
        cond_legal_o = (cond_i[1:0] != 2'b00);
        cond_true_o  = cond_legal_o & (base ^ cond_i[2]);
    end

endmodule

// File: rtl/rcb_target_calc.sv
module rcb_target_calc
    import rcb_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [AW-1:0]     pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [AW-1:0]     target_o
);

    localparam int OFS_W = DISP_W + 2;

    logic [OFS_W-1:0] ofs_short;
    logic [AW-1:0]    ofs_full;

    assign ofs_short = {disp_i, 2'b00};

    generate
        if (AW > OFS_W) begin : g_sext
            assign ofs_full = {{(AW-OFS_W){disp_i[DISP_W-1]}}, ofs_short};
        end else begin : g_trunc
            assign ofs_full = ofs_short[AW-1:0];
        end
    endgenerate

    assign target_o = pc_i + ofs_full;

endmodule

// File: rtl/rcb_branch_unit.sv
module rcb_branch_unit
    import rcb_pkg::*;
#(
    parameter int              AW       = 64,
    parameter int              XLEN     = 64,
    parameter logic [AW-1:0]   RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid_i,
    input  logic [INSN_W-1:0]  instr_i,
    input  logic [XLEN-1:0]    rs_value_i,
    output logic [AW-1:0]      pc_o,
    output logic [AW-1:0]      npc_o,
    output logic               slot_kill_o,
    output logic               is_branch_o,
    output logic               br_taken_o,
    output logic [AW-1:0]      br_target_o,
    output logic               illegal_o,
    output logic               hint_o,
    output logic [REG_IDX-1:0] src_reg_o
);

    localparam logic [AW-1:0] STEP = AW'(4);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] npc;
        logic          kill;
    } seq_t;

    seq_t        st_d, st_q;
    rcb_fields_t fld;
    logic        cond_true;
    logic        cond_legal;
    logic [AW-1:0] target;
    logic        live;
    logic        branch_here;
    logic        bad_enc;
    logic        take;
    logic        annul_next;

    rcb_field_decode u_decode (
        .word_i   (instr_i),
        .fields_o (fld)
    );

    rcb_cond_eval #(.XLEN(XLEN)) u_cond (
        .cond_i       (fld.cond),
        .value_i      (rs_value_i),
        .cond_true_o  (cond_true),
        .cond_legal_o (cond_legal)
    );

    rcb_target_calc #(.AW(AW)) u_target (
        .pc_i     (st_q.pc),
        .disp_i   (fld.disp),
        .target_o (target)
    );

    always_comb begin
        live        = issue_valid_i & ~st_q.kill;
        branch_here = live & fld.is_reg_br;
        bad_enc     = branch_here & (fld.rsvd_bit | ~cond_legal);
        take        = branch_here & ~bad_enc & cond_true;
        annul_next  = branch_here & ~bad_enc & ~cond_true & fld.annul;

        st_d = st_q;
        if (issue_valid_i && !bad_enc) begin
            st_d.pc   = st_q.npc;
            st_d.npc  = take ? target : (st_q.npc + STEP);
            st_d.kill = annul_next;
        end else if (issue_valid_i) begin
            st_d.kill = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc   <= RESET_PC;
            st_q.npc  <= RESET_PC + STEP;
            st_q.kill <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o        = st_q.pc;
    assign npc_o       = st_q.npc;
    assign slot_kill_o = st_q.kill;
    assign is_branch_o = branch_here;
    assign br_taken_o  = take;
    assign br_target_o = target;
    assign illegal_o   = bad_enc;
    assign hint_o      = branch_here & fld.hint;
    assign src_reg_o   = fld.src_reg;

endmodule

// File: rtl/rcb_branch_unit_chk.sv
module rcb_branch_unit_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_valid_i,
    input logic [AW-1:0] pc_o,
    input logic [AW-1:0] npc_o,
    input logic          slot_kill_o,
    input logic          br_taken_o,
    input logic [AW-1:0] br_target_o,
    input logic          illegal_o,
    input logic          hint_o
);

    AST_TAKEN_TO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken_o |=> (npc_o == $past(br_target_o)));                // R6

    AST_PC_FROM_NPC: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && !illegal_o) |=> (pc_o == $past(npc_o)));    // R6

    AST_ILLEGAL_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !br_taken_o);                                   // R9

    AST_ILLEGAL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> ($stable(pc_o) && $stable(npc_o) && !slot_kill_o)); // R9

    AST_KILLED_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_kill_o && issue_valid_i) |-> (!br_taken_o && !illegal_o && !hint_o)); // R7

    AST_KILL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_kill_o && issue_valid_i) |=> !slot_kill_o);             // R7

    AST_TAKEN_NO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken_o |=> !slot_kill_o);                                 // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid_i |=> ($stable(pc_o) && $stable(npc_o) && $stable(slot_kill_o))); // R11

endmodule

bind rcb_branch_unit rcb_branch_unit_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid_i (issue_valid_i),
    .pc_o          (pc_o),
    .npc_o         (npc_o),
    .slot_kill_o   (slot_kill_o),
    .br_taken_o    (br_taken_o),
    .br_target_o   (br_target_o),
    .illegal_o     (illegal_o),
    .hint_o        (hint_o)
);

// File: tb/rcb_branch_unit_tb_top.sv
module rcb_branch_unit_tb_top;

    localparam int          AW     = 64;
    localparam int          XLEN   = 64;
    localparam logic [63:0] RST_PC = 64'h0000_0000_0000_1000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              issue_valid;
    logic [31:0]       instr;
    logic [XLEN-1:0]   rs_val;
    logic [AW-1:0]     pc_o, npc_o, br_target_o;
    logic              slot_kill_o, is_branch_o, br_taken_o, illegal_o, hint_o;
    logic [4:0]        src_reg_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [63:0] m_pc, m_npc;
    logic        m_kill;

    always #5 clk = ~clk;

    rcb_branch_unit #(.AW(AW), .XLEN(XLEN), .RESET_PC(RST_PC)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_valid_i (issue_valid),
        .instr_i       (instr),
        .rs_value_i    (rs_val),
        .pc_o          (pc_o),
        .npc_o         (npc_o),
        .slot_kill_o   (slot_kill_o),
        .is_branch_o   (is_branch_o),
        .br_taken_o    (br_taken_o),
        .br_target_o   (br_target_o),
        .illegal_o     (illegal_o),
        .hint_o        (hint_o),
        .src_reg_o     (src_reg_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_br(input bit a, input bit rsv, input logic [2:0] rc,
                                          input bit p, input logic [15:0] d);
        return {2'b00, a, rsv, rc, 3'b011, d[15:14], p, 5'd3, d[13:0]};
    endfunction

    function automatic bit ref_cond(input logic [2:0] rc, input logic [63:0] v);
        case (rc)
            3'd1:    return $signed(v) == 0;
            3'd2:    return $signed(v) <= 0;
            3'd3:    return $signed(v) <  0;
            3'd5:    return $signed(v) != 0;
            3'd6:    return $signed(v) >  0;
            3'd7:    return $signed(v) >= 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_state(input string req);
        chk(pc_o === m_pc,          {req, " pc"},   pc_o,  m_pc);
        chk(npc_o === m_npc,        {req, " npc"},  npc_o, m_npc);
        chk(slot_kill_o === m_kill, {req, " kill"}, 64'(slot_kill_o), 64'(m_kill));
    endtask

    // Entered just after a falling edge; leaves just after the next one.
    task automatic issue(input logic [31:0] w, input logic [63:0] v, input string req);
        logic        br, ill, tk, an;
        logic [15:0] d;
        logic [63:0] tgt;
        instr = w; rs_val = v; issue_valid = 1'b1;
        #1;
        d   = {w[21:20], w[13:0]};
        br  = !m_kill && (w[31:30] == 2'b00) && (w[24:22] == 3'b011);
        ill = br && (w[28] || (w[26:25] == 2'b00));
        tk  = br && !ill && ref_cond(w[27:25], v);
        an  = br && !ill && !tk && w[29];
        tgt = m_pc + {{46{d[15]}}, d, 2'b00};
        chk(br_taken_o === tk,        {req, " taken"},   64'(br_taken_o), 64'(tk));
        chk(illegal_o === ill,        {req, " illegal"}, 64'(illegal_o),  64'(ill));
        chk(hint_o === (br & w[19]),  {req, " hint"},    64'(hint_o),     64'(br & w[19]));
        if (br && !ill)
            chk(br_target_o === tgt,  {req, " target"},  br_target_o,     tgt);
        @(posedge clk);
        #1;
        issue_valid = 1'b0;
        if (!ill) begin
            m_pc   = m_npc;
            m_npc  = tk ? tgt : m_npc + 64'd4;
            m_kill = an;
        end
        @(negedge clk);
        #1;
        check_state(req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; issue_valid = 1'b0; instr = '0; rs_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        m_pc = RST_PC; m_npc = RST_PC + 64'd4; m_kill = 1'b0;
        check_state("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk); #1;
        check_state("R1 after reset");
    endtask

    task automatic t_plain();
        issue(32'h8000_0000, 64'd0, "R2 op 10 word");
        issue({2'b00, 1'b0, 1'b0, 3'd1, 3'b010, 22'h0}, 64'd0, "R2 other op2");
        issue(32'hC6A0_1234, 64'h5, "R2 op 11 word");
    endtask

    task automatic t_zero_family();
        issue(mk_br(0, 0, 3'd1, 0, 16'd8), 64'd0, "R3 eq zero taken");
        issue(mk_br(0, 0, 3'd1, 0, 16'd8), 64'd1, "R3 eq nonzero");
        issue(mk_br(0, 0, 3'd2, 0, 16'd4), 64'hFFFF_FFFF_FFFF_FFFF, "R3 le minus one");
        issue(mk_br(0, 0, 3'd2, 0, 16'd4), 64'h7FFF_FFFF_FFFF_FFFF, "R3 le max positive");
        issue(mk_br(0, 0, 3'd3, 0, 16'd4), 64'h8000_0000_0000_0000, "R3 lt min negative");
        issue(mk_br(0, 0, 3'd3, 0, 16'd4), 64'd0, "R3 lt zero");
    endtask

    task automatic t_nonzero_family();
        issue(mk_br(0, 0, 3'd5, 0, 16'd12), 64'h0000_0001_0000_0000, "R4 ne upper bit");
        issue(mk_br(0, 0, 3'd5, 0, 16'd12), 64'd0, "R4 ne zero");
        issue(mk_br(0, 0, 3'd6, 0, 16'd12), 64'd0, "R4 gt zero");
        issue(mk_br(0, 0, 3'd6, 0, 16'd12), 64'd7, "R4 gt positive");
        issue(mk_br(0, 0, 3'd7, 0, 16'd12), 64'd0, "R4 ge zero");
        issue(mk_br(0, 0, 3'd7, 0, 16'd12), 64'h8000_0000_0000_0001, "R4 ge negative");
    endtask

    task automatic t_target();
        issue(mk_br(0, 0, 3'd1, 0, 16'h8000), 64'd0, "R5 R6 most negative disp");
        issue(32'h8000_0000, 64'd0, "R6 delay slot");
        issue(mk_br(0, 0, 3'd1, 0, 16'h7FFF), 64'd0, "R5 R6 most positive disp");
        issue(mk_br(0, 0, 3'd1, 0, 16'hC001), 64'd0, "R5 split fields");
    endtask

    task automatic t_annul();
        issue(mk_br(1, 0, 3'd5, 0, 16'd40), 64'd0, "R7 annul falls through");
        issue(32'h8000_0000, 64'd0, "R7 killed plain slot");
        issue(mk_br(1, 0, 3'd5, 0, 16'd40), 64'd9, "R8 annul but taken");
        issue(mk_br(0, 0, 3'd5, 0, 16'd40), 64'd0, "R8 no annul not taken");
    endtask

    task automatic t_kill_collision();
        issue(mk_br(1, 0, 3'd1, 0, 16'd20), 64'd3, "R7 arm kill");
        issue(mk_br(0, 0, 3'd1, 1, 16'd20), 64'd0, "R7 killed taken branch");
        issue(mk_br(1, 0, 3'd6, 0, 16'd20), 64'd0, "R7 arm kill again");
        issue(mk_br(0, 1, 3'd0, 1, 16'd20), 64'd0, "R7 killed illegal word");
        issue(mk_br(0, 0, 3'd1, 0, 16'd20), 64'd0, "R7 normal after kill");
    endtask

    task automatic t_illegal();
        issue(mk_br(0, 0, 3'd0, 0, 16'd4), 64'd0, "R9 code 0");
        issue(mk_br(1, 0, 3'd4, 0, 16'd4), 64'd0, "R9 code 4 with annul");
        issue(mk_br(0, 1, 3'd1, 0, 16'd4), 64'd0, "R9 reserved bit");
    endtask

    task automatic t_hint();
        issue(mk_br(0, 0, 3'd1, 1, 16'd4), 64'd0, "R10 hint set taken");
        issue(mk_br(0, 0, 3'd1, 1, 16'd4), 64'd1, "R10 hint set not taken");
        issue(32'h8008_0000, 64'd0, "R10 bit19 on plain word");
    endtask

    task automatic t_idle();
        instr = mk_br(0, 0, 3'd1, 0, 16'd4); rs_val = '0; issue_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check_state("R11 idle hold");
        issue(mk_br(1, 0, 3'd5, 0, 16'd4), 64'd0, "R11 arm kill");
        repeat (2) @(negedge clk);
        #1;
        check_state("R11 kill held idle");
        issue(32'h8000_0000, 64'd0, "R11 kill consumed");
    endtask

    initial begin
        t_reset();
        t_plain();
        t_zero_family();
        t_nonzero_family();
        t_target();
        t_annul();
        t_kill_collision();
        t_illegal();
        t_hint();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule